// File: doc/BRIEF.md
# Strobe-Sampled Quadrature Position Counter with Detent Clicks

This block turns the two phase signals of an incremental rotary encoder into a signed position count. Both phases enter through a two-flop sampler whose flops advance only when a slow sample strobe is high. The strobe rate therefore sets the highest edge rate the block can follow, and the sampler also guards against metastability. Each settled sample is compared with the one before it. The pair of states is classified as a forward step, a reverse step, no movement, or an illegal jump in which both phases changed.

Valid steps change a wrapping position register and produce one-cycle step pulses. A detent accumulator turns every net group of four steps in one direction into a single click pulse, which suits hand-turned controls that move through a whole Gray cycle per notch. A swap input reverses the sense of counting, with the same effect as exchanging the two phase wires. An illegal jump raises a one-cycle flag and leaves the count alone. The stored state still takes the new sample, so decoding resumes from there.

Top module: `quad_detent_counter`

## Requirements
- R1: A phase change reaches the decoder only after the sample strobe has been high on two clock edges. With the strobe held low, phase activity of any kind changes no output. Any step or illegal pulse appears one clock after the strobe edge that moved the second sampler stage.
- R2: While rst_n is low, the position, the detent accumulator and all pulse outputs clear, and dir_up is 0. Both sampler stages and the stored previous state load the current phase levels, so no step follows reset when the phases are steady.
- R3: The phase state is the bit pair {ph_x, ph_y}. With swap_dir low, the order 00, 01, 11, 10, 00 is forward. Each forward transition adds one to pos and pulses step_up for exactly one cycle.
- R4: With swap_dir low, the reverse order (00, 10, 11, 01, 00) subtracts one from pos per transition and pulses step_dn for one cycle.
- R5: A transition in which both phases change pulses illegal for one cycle. It leaves pos and the detent accumulator unchanged and raises no step pulse. The new state becomes the reference for the next transition.
- R6: A detent accumulator counts valid steps. Reaching +4 pulses click_up, and reaching -4 pulses click_dn, in the same cycle as the step that completed it. The accumulator then returns to zero.
- R7: After a direction reversal, the count and the accumulator track the net movement exactly. A reversal inside a detent cancels partial progress and emits no click. The only uncertainty is the one step of travel that is inherent at the turn.
- R8: With swap_dir high, the forward Gray order decrements and the reverse order increments. Illegal jumps stay illegal.
- R9: pos is a 16-bit two's-complement count that wraps silently: one decrement from 0 gives 16'hFFFF, and one increment from 16'hFFFF gives 0.
- R10: dir_up shows the direction of the most recent valid step (1 = increment). It holds across idle cycles and illegal jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample strobe that advances the phase sampler |
| ph_x | input | 1 | Encoder phase X, asynchronous |
| ph_y | input | 1 | Encoder phase Y, asynchronous |
| swap_dir | input | 1 | Reverses the counting sense |
| pos | output | 16 | Signed wrapping position count |
| step_up | output | 1 | One-cycle pulse per increment |
| step_dn | output | 1 | One-cycle pulse per decrement |
| click_up | output | 1 | One-cycle pulse per forward detent |
| click_dn | output | 1 | One-cycle pulse per reverse detent |
| dir_up | output | 1 | Direction of the last valid step |
| illegal | output | 1 | One-cycle pulse on a double-phase jump |

## Verification
Some properties are checked on every cycle. Each step pulse must move pos by exactly one in its own direction. An illegal pulse or an idle cycle must leave pos unchanged. No pulse may appear unless the strobe was high two edges earlier. Clicks may only coincide with a step in the same direction. Swap must invert the classifier's raw direction, and dir_up must agree with the latest step. Other behaviour only the bench scenarios can show: whether the decoder classifies every Gray pair correctly, and whether the accumulator counts exactly four net steps per click across reversals. The same holds for the silent wrap at zero, the resynchronisation after an illegal jump, and the fact that activity with the strobe held low is invisible.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_FWD  = 2'd1,
    MV_REV  = 2'd2,
    MV_BAD  = 2'd3
  } mv_e;

  // Rank of a phase pair along the forward Gray cycle 00,01,11,10.
  function automatic logic [1:0] gray_rank(input logic [1:0] ph);
    return {ph[1], ph[1] ^ ph[0]};
  endfunction

  // Index is {prev_x, prev_y, cur_x, cur_y}.
  function automatic mv_e classify(input logic [3:0] idx);
    logic [1:0] delta;
    delta = gray_rank(idx[1:0]) - gray_rank(idx[3:2]);
    case (delta)
      2'd1:    return MV_FWD;
      2'd3:    return MV_REV;
      2'd2:    return MV_BAD;
      default: return MV_NONE;
    endcase
  endfunction

  function automatic mv_e apply_swap(input mv_e mv, input logic swap);
    if (!swap) return mv;
    case (mv)
      MV_FWD:  return MV_REV;
      MV_REV:  return MV_FWD;
      default: return mv;
    endcase
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n)  stage[0] <= din;
          else if (en) stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n)  stage[i] <= din;
          else if (en) stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/qdec_xlate.sv
module qdec_xlate
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] init_ph,
  input  logic [1:0] cur_ph,
  input  logic       swap,
  output mv_e        raw_mv,
  output mv_e        eff_mv
);

  logic [1:0] prev_ph;

  // The reference always follows the sample, so an illegal jump resynchronises.
  always_ff @(posedge clk) begin
    if (!rst_n) prev_ph <= init_ph;
    else        prev_ph <= cur_ph;
  end

  assign raw_mv = classify({prev_ph, cur_ph});
  assign eff_mv = apply_swap(raw_mv, swap);

endmodule

// File: rtl/qdec_detent.sv
module qdec_detent #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic click_up,
  output logic click_dn
);

  localparam int AW = $clog2(DIV) + 1;
  localparam logic signed [AW-1:0] HI = AW'(DIV - 1);
  localparam logic signed [AW-1:0] LO = -HI;

  logic signed [AW-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      click_up <= 1'b0;
      click_dn <= 1'b0;
    end else begin
      click_up <= 1'b0;
      click_dn <= 1'b0;
      if (inc) begin
        if (acc == HI) begin
          acc      <= '0;
          click_up <= 1'b1;
        end else begin
          acc <= acc + AW'(1);
        end
      end else if (dec) begin
        if (acc == LO) begin
          acc      <= '0;
          click_dn <= 1'b1;
        end else begin
          acc <= acc - AW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/quad_detent_counter.sv
module quad_detent_counter
  import qdec_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int DETENT_DIV = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             ph_x,
  input  logic             ph_y,
  input  logic             swap_dir,
  output logic [POS_W-1:0] pos,
  output logic             step_up,
  output logic             step_dn,
  output logic             click_up,
  output logic             click_dn,
  output logic             dir_up,
  output logic             illegal
);

  function automatic logic [POS_W-1:0] next_pos(
    input logic [POS_W-1:0] cur, input logic up, input logic dn);
    if (up)      return cur + POS_W'(1);
    else if (dn) return cur - POS_W'(1);
    else         return cur;
  endfunction

  logic [1:0] raw_ph;
  logic [1:0] sync_ph;
  mv_e        raw_mv;
  mv_e        eff_mv;

  // Named events for the checker
  logic evt_fwd, evt_rev, evt_bad, evt_up, evt_dn;

  assign raw_ph = {ph_x, ph_y};

  qdec_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (smp_en),
    .din   (raw_ph),
    .dout  (sync_ph)
  );

  qdec_xlate u_xlate (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_ph (raw_ph),
    .cur_ph  (sync_ph),
    .swap    (swap_dir),
    .raw_mv  (raw_mv),
    .eff_mv  (eff_mv)
  );

  assign evt_fwd = (raw_mv == MV_FWD);
  assign evt_rev = (raw_mv == MV_REV);
  assign evt_bad = (raw_mv == MV_BAD);
  assign evt_up  = (eff_mv == MV_FWD);
  assign evt_dn  = (eff_mv == MV_REV);

  qdec_detent #(.DIV(DETENT_DIV)) u_detent (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (evt_up),
    .dec      (evt_dn),
    .click_up (click_up),
    .click_dn (click_dn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      step_up <= 1'b0;
      step_dn <= 1'b0;
      illegal <= 1'b0;
      dir_up  <= 1'b0;
    end else begin
      pos     <= next_pos(pos, evt_up, evt_dn);
      step_up <= evt_up;
      step_dn <= evt_dn;
      illegal <= evt_bad;
      if (evt_up)      dir_up <= 1'b1;
      else if (evt_dn) dir_up <= 1'b0;
    end
  end

endmodule

// File: rtl/quad_detent_counter_chk.sv
module quad_detent_counter_chk #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic             swap_dir,
  input logic [POS_W-1:0] pos,
  input logic             step_up,
  input logic             step_dn,
  input logic             click_up,
  input logic             click_dn,
  input logic             dir_up,
  input logic             illegal,
  input logic             evt_fwd,
  input logic             evt_rev
);

  a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, illegal}));

  a_r3_inc_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> pos == $past(pos) + POS_W'(1));

  a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> pos == $past(pos) - POS_W'(1));

  a_r5_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(pos));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up || step_dn) |-> $stable(pos));

  a_r1_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn || illegal) |-> $past(smp_en, 2));

  a_r6_click_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    click_up |-> step_up);

  a_r6_click_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
    click_dn |-> step_dn);

  a_r8_swap_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> $past(swap_dir ? evt_rev : evt_fwd));

  a_r8_swap_dn: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> $past(swap_dir ? evt_fwd : evt_rev));

  a_r10_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> dir_up);

  a_r10_dir_dn: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> !dir_up);

endmodule

bind quad_detent_counter quad_detent_counter_chk #(.POS_W(POS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_en   (smp_en),
  .swap_dir (swap_dir),
  .pos      (pos),
  .step_up  (step_up),
  .step_dn  (step_dn),
  .click_up (click_up),
  .click_dn (click_dn),
  .dir_up   (dir_up),
  .illegal  (illegal),
  .evt_fwd  (evt_fwd),
  .evt_rev  (evt_rev)
);

// File: tb/quad_detent_counter_tb.sv
module quad_detent_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic        ph_x = 1'b0;
  logic        ph_y = 1'b0;
  logic        swap_dir = 1'b0;
  logic [15:0] pos;
  logic        step_up, step_dn, click_up, click_dn, dir_up, illegal;

  int checks = 0;
  int fails  = 0;
  bit stb_on = 1'b1;
  bit done   = 1'b0;
  int stb_cnt = 0;

  // Observed pulse tallies
  int n_click_up = 0, n_click_dn = 0, n_illegal = 0;

  // Forward Gray order as {x,y} codes
  int gray_seq [4] = '{0, 1, 3, 2};
  int cur_idx = 0;

  // Reference model state
  int m_s1, m_s2, m_prev, m_acc;
  int m_pos;
  bit m_up, m_dn, m_cu, m_cd, m_dir, m_bad;

  always #2.5 clk = ~clk;

  quad_detent_counter u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ph_x(ph_x), .ph_y(ph_y),
    .swap_dir(swap_dir), .pos(pos), .step_up(step_up), .step_dn(step_dn),
    .click_up(click_up), .click_dn(click_dn), .dir_up(dir_up), .illegal(illegal)
  );

  function automatic int rank_of(int code);
    for (int k = 0; k < 4; k++) if (gray_seq[k] == code) return k;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Strobe: one cycle high in every four
  always @(negedge clk) begin
    stb_cnt = (stb_cnt + 1) % 4;
    smp_en = stb_on && (stb_cnt == 0);
  end

  // Reference model, advanced at each rising edge
  always @(posedge clk) begin
    int raw, d;
    raw = ph_x * 2 + ph_y;
    if (!rst_n) begin
      m_s1 = raw; m_s2 = raw; m_prev = raw;
      m_pos = 0; m_acc = 0;
      m_up = 0; m_dn = 0; m_cu = 0; m_cd = 0; m_bad = 0; m_dir = 0;
    end else begin
      d = (rank_of(m_s2) - rank_of(m_prev) + 4) % 4;
      m_up = 0; m_dn = 0; m_cu = 0; m_cd = 0; m_bad = (d == 2);
      if (d == 1) begin if (swap_dir) m_dn = 1; else m_up = 1; end
      if (d == 3) begin if (swap_dir) m_up = 1; else m_dn = 1; end
      if (m_up) begin
        m_pos = (m_pos + 1) % 65536; m_dir = 1; m_acc++;
        if (m_acc == 4) begin m_acc = 0; m_cu = 1; end
      end
      if (m_dn) begin
        m_pos = (m_pos + 65535) % 65536; m_dir = 0; m_acc--;
        if (m_acc == -4) begin m_acc = 0; m_cd = 1; end
      end
      m_prev = m_s2;
      if (smp_en) begin m_s2 = m_s1; m_s1 = raw; end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pos == 16'(m_pos), "R3/R4/R9 pos vs model", int'(pos), m_pos);
      chk(step_up == m_up, "R3/R8 step_up vs model", step_up, m_up);
      chk(step_dn == m_dn, "R4/R8 step_dn vs model", step_dn, m_dn);
      chk(click_up == m_cu, "R6/R7 click_up vs model", click_up, m_cu);
      chk(click_dn == m_cd, "R6/R7 click_dn vs model", click_dn, m_cd);
      chk(illegal == m_bad, "R5 illegal vs model", illegal, m_bad);
      chk(dir_up == m_dir, "R10 dir_up vs model", dir_up, m_dir);
      n_click_up += click_up;
      n_click_dn += click_dn;
      n_illegal  += illegal;
    end
  end

  task automatic put_state(int code, int settle);
    @(negedge clk);
    ph_x = code[1];
    ph_y = code[0];
    repeat (settle) @(negedge clk);
  endtask

  task automatic go_fwd(int n);
    for (int i = 0; i < n; i++) begin
      cur_idx = (cur_idx + 1) % 4;
      put_state(gray_seq[cur_idx], 12);
    end
  endtask

  task automatic go_rev(int n);
    for (int i = 0; i < n; i++) begin
      cur_idx = (cur_idx + 3) % 4;
      put_state(gray_seq[cur_idx], 12);
    end
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R2: outputs cleared during reset
    chk(pos == 0 && !step_up && !step_dn && !illegal && !dir_up && !click_up && !click_dn,
        "R2 reset outputs", int'(pos), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(pos == 0, "R2 no step after reset", int'(pos), 0);

    go_fwd(4);
    chk(pos == 16'd4, "R3 four forward steps", int'(pos), 4);
    chk(n_click_up == 1, "R6 one click after four steps", n_click_up, 1);
    chk(dir_up == 1'b1, "R10 dir after forward", dir_up, 1);

    go_rev(5);
    chk(pos == 16'hFFFF, "R9 wrap below zero", int'(pos), 65535);
    chk(dir_up == 1'b0, "R10 dir after reverse", dir_up, 0);
    go_rev(1);
    chk(pos == 16'hFFFE, "R4 reverse count", int'(pos), 65534);
    chk(n_click_dn == 1, "R6 one reverse click", n_click_dn, 1);

    go_fwd(2);
    chk(pos == 16'd0, "R7 reversal back to zero", int'(pos), 0);
    chk(n_click_up == 1 && n_click_dn == 1, "R7 no click on partial detent",
        n_click_up + n_click_dn, 2);

    // R1: phase moves with the strobe held low
    stb_on = 1'b0;
    cur_idx = (cur_idx + 1) % 4;
    put_state(gray_seq[cur_idx], 3);
    put_state(gray_seq[(cur_idx + 3) % 4], 3);
    put_state(gray_seq[cur_idx], 30);
    chk(pos == 16'd0, "R1 no change without strobe", int'(pos), 0);
    stb_on = 1'b1;
    repeat (16) @(negedge clk);
    chk(pos == 16'd1, "R1 change after strobes", int'(pos), 1);

    // R5: double-phase jump, then resume from the new state
    cur_idx = (cur_idx + 2) % 4;
    put_state(gray_seq[cur_idx], 12);
    chk(n_illegal == 1, "R5 illegal pulse", n_illegal, 1);
    chk(pos == 16'd1, "R5 pos held on jump", int'(pos), 1);
    chk(dir_up == 1'b1, "R10 dir held on jump", dir_up, 1);
    go_fwd(1);
    chk(pos == 16'd2, "R5 resync after jump", int'(pos), 2);

    // R8: swapped sense
    swap_dir = 1'b1;
    go_fwd(3);
    chk(pos == 16'hFFFF, "R8 swap forward decrements", int'(pos), 65535);
    go_rev(1);
    chk(pos == 16'd0, "R9 wrap above all ones", int'(pos), 0);
    chk(dir_up == 1'b1, "R8 swap reverse increments", dir_up, 1);
    swap_dir = 1'b0;
    go_fwd(8);
    chk(pos == 16'd8, "R6 long forward run", int'(pos), 8);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule